// File: doc/BRIEF.md
# Interpolate-by-8 Root-Raised-Cosine Pulse Shaper

This block shapes one rail (I or Q) of a burst QPSK transmitter. On each symbol strobe it takes one antipodal symbol (+1, -1, or 0 to flush). It then produces eight filtered samples per symbol period for a 9-bit digital-to-analog converter. The filter is a fixed 64-tap root-raised-cosine response with a roll-off of 0.5. At 128 kbaud in, the sample strobe runs at 1.024 MHz. A transmitter instantiates two copies, one per rail, and drives both from the same strobes.

The filter is split into eight polyphase branches. Each output needs only the eight taps of one phase, applied to the eight most recent symbols. The symbols are restricted to ±1 or 0, so every product reduces to adding, subtracting or skipping a coefficient. No multiplier is needed.

A run input gates the burst. While run is low the symbol history is wiped, so each burst starts from a quiet filter and the output reads zero.

Top module: `pulse_shaper_x8`

## Requirements
- R1: While rst_n is low, and after its release, smp_out is 0 and smp_vld is 0. The symbol history is empty and the phase is 0, so the first sample produced after reset, before any symbol, is 0.
- R2: sym_code encodes 2'b01 as +1 and 2'b11 as -1; 2'b00 and 2'b10 both mean 0. A sym_stb with run high shifts the code into an 8-entry history as the newest entry and drops the oldest.
- R3: A sym_stb with run high sets the output phase to 0. Each smp_stb without sym_stb advances the phase by one, wrapping from 7 to 0. When both strobes arrive in one cycle, the sample uses the old phase and the phase then becomes 0.
- R4: A smp_stb at a clock edge gives, one cycle later, smp_out = sum over i=0..7 of s[i]*c[k+8i]. Here k is the phase and s[0] the newest symbol, both as they stood before that edge.
- R5: The coefficients are symmetric, c[n] = c[63-n]. For n = 32..63 they are 200, 186, 158, 123, 83, 45, 13, -11, -24, -29, -26, -18, -9, 0, 5, 8, 7, 4, 1, -2, -3, -3, -2, 0, 1, 3, 3, 2, 1, 0, -1, -2. A lone +1 symbol followed by zero symbols, with eight samples per symbol, therefore reads out c[0..63] in order.
- R6: smp_out is 9-bit two's complement and saturates to [-256, 255]. The largest phase magnitude is 253, so the sign pattern aligned to phase 0 gives exactly +253 (or -253 when negated), with no clipping.
- R7: While run is low, the history and phase are cleared on every clock, sym_stb is ignored, and each smp_stb yields a 0 sample. After run returns high, only symbols accepted since then contribute.
- R8: smp_vld is high for exactly the cycle after each smp_stb and low otherwise. smp_out holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Burst enable; low clears the filter and silences the output |
| sym_stb | input | 1 | Accepts sym_code as a new symbol |
| sym_code | input | 2 | Symbol code: 01 = +1, 11 = -1, else 0 |
| smp_stb | input | 1 | Requests one output sample at 8x the symbol rate |
| smp_out | output | 9 | Signed filtered sample |
| smp_vld | output | 1 | One-cycle marker that smp_out was updated |

## Verification
Positive and negative single-symbol impulses read out all 64 coefficients in order. They separate a wrong tap, wrong symmetry or a swapped sign from a correct filter. Code 2'b10 is sent as an impulse to show that it flushes rather than counts as -1. A sign pattern aligned to the largest phase exposes the 253 peak, which separates an off-by-one lane-to-tap mapping and any premature clipping. A long pseudo-random symbol run checks the full polyphase sum. Irregular strobe spacing, a coincident symbol and sample strobe, and run toggles mid-burst distinguish the phase reset, the wrap and the history clearing.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  // Polyphase geometry of the fixed filter.
  localparam int unsigned UPS  = 8;
  localparam int unsigned TAPS = 64;
  localparam int unsigned NSYM = TAPS / UPS;
  localparam int unsigned PH_W = $clog2(UPS);
  localparam int unsigned CF_W = 9;

  typedef logic [1:0] sym_code_t;

  localparam sym_code_t SYM_POS = 2'b01;
  localparam sym_code_t SYM_NEG = 2'b11;

  // Symmetric coefficient set: half-table indexed by distance from centre.
  function automatic logic signed [CF_W-1:0] tap_coef(input int unsigned n);
    int unsigned j;
    if (n >= TAPS / 2) j = n - TAPS / 2;
    else               j = TAPS / 2 - 1 - n;
    case (j)
      0:  tap_coef = 9'sd200;
      1:  tap_coef = 9'sd186;
      2:  tap_coef = 9'sd158;
      3:  tap_coef = 9'sd123;
      4:  tap_coef = 9'sd83;
      5:  tap_coef = 9'sd45;
      6:  tap_coef = 9'sd13;
      7:  tap_coef = -9'sd11;
      8:  tap_coef = -9'sd24;
      9:  tap_coef = -9'sd29;
      10: tap_coef = -9'sd26;
      11: tap_coef = -9'sd18;
      12: tap_coef = -9'sd9;
      13: tap_coef = 9'sd0;
      14: tap_coef = 9'sd5;
      15: tap_coef = 9'sd8;
      16: tap_coef = 9'sd7;
      17: tap_coef = 9'sd4;
      18: tap_coef = 9'sd1;
      19: tap_coef = -9'sd2;
      20: tap_coef = -9'sd3;
      21: tap_coef = -9'sd3;
      22: tap_coef = -9'sd2;
      23: tap_coef = 9'sd0;
      24: tap_coef = 9'sd1;
      25: tap_coef = 9'sd3;
      26: tap_coef = 9'sd3;
      27: tap_coef = 9'sd2;
      28: tap_coef = 9'sd1;
      29: tap_coef = 9'sd0;
      30: tap_coef = -9'sd1;
      31: tap_coef = -9'sd2;
      default: tap_coef = 9'sd0;
    endcase
  endfunction

endpackage

// File: rtl/shaper_history.sv
module shaper_history
  import shaper_pkg::*;
#(
  parameter int unsigned DEPTH = NSYM
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  sym_stb,
  input  sym_code_t             sym_code,
  output logic [DEPTH-1:0][1:0] hist
);

  logic [DEPTH-1:0][1:0] hist_q;
  logic [DEPTH-1:0][1:0] hist_nxt;

  always_comb begin
    hist_nxt = hist_q;
    if (!run)
      hist_nxt = '0;
    else if (sym_stb)
      hist_nxt = {hist_q[DEPTH-2:0], sym_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end

  assign hist = hist_q;

  // R7: disabled burst leaves an empty history
  assert_hist_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hist_q == '0));

  // R2: newest code enters slot 0, older ones move down one slot
  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sym_stb) |=> (hist_q[0] == $past(sym_code)) && (hist_q[1] == $past(hist_q[0])));

  // R2: without a symbol strobe the history does not move
  assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sym_stb) |=> $stable(hist_q));

endmodule

// File: rtl/shaper_phase.sv
module shaper_phase
  import shaper_pkg::*;
#(
  parameter int unsigned NPH = UPS,
  localparam int unsigned PW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sym_stb,
  input  logic          smp_stb,
  output logic [PW-1:0] phase
);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;

  always_comb begin
    phase_nxt = phase_q;
    if (!run || sym_stb)
      phase_nxt = '0;
    else if (smp_stb)
      phase_nxt = (32'(phase_q) == NPH - 1) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nxt;
  end

  assign phase = phase_q;

  // R3: a new symbol restarts the sample phase
  assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sym_stb) |=> (phase_q == '0));

  // R3: each lone sample strobe steps the phase modulo the ratio
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && smp_stb && !sym_stb) |=> (phase_q == PW'((32'($past(phase_q)) + 1) % NPH)));

endmodule

// File: rtl/shaper_mac.sv
module shaper_mac
  import shaper_pkg::*;
#(
  parameter int unsigned OUT_W = 9,
  parameter int unsigned ACC_W = OUT_W + 4
) (
  input  logic [NSYM-1:0][1:0]     hist,
  input  logic [PH_W-1:0]          phase,
  output logic signed [ACC_W-1:0]  acc,
  output logic signed [OUT_W-1:0]  sat
);

  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(2 ** (OUT_W - 1)));

  logic signed [ACC_W-1:0] term [NSYM];

  // One lane per stored symbol: select the phase tap, then add/sub/skip.
  for (genvar i = 0; i < NSYM; i++) begin : g_lane
    logic signed [CF_W-1:0]  cf;
    logic signed [ACC_W-1:0] cf_x;
    assign cf   = tap_coef(32'(phase) + UPS * i);
    assign cf_x = {{(ACC_W - CF_W){cf[CF_W-1]}}, cf};
    assign term[i] = (hist[i] == SYM_POS) ? cf_x :
                     (hist[i] == SYM_NEG) ? -cf_x : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSYM; i++)
      acc = acc + term[i];
  end

  always_comb begin
    if (acc > SAT_HI)      sat = SAT_HI[OUT_W-1:0];
    else if (acc < SAT_LO) sat = SAT_LO[OUT_W-1:0];
    else                   sat = acc[OUT_W-1:0];
  end

endmodule

// File: rtl/pulse_shaper_x8.sv
module pulse_shaper_x8
  import shaper_pkg::*;
#(
  parameter int unsigned OUT_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    sym_stb,
  input  logic [1:0]              sym_code,
  input  logic                    smp_stb,
  output logic signed [OUT_W-1:0] smp_out,
  output logic                    smp_vld
);

  localparam int unsigned ACC_W = OUT_W + $clog2(NSYM) + 1;
  localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] LIM_LO = ACC_W'(-(2 ** (OUT_W - 1)));

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NSYM-1:0][1:0]     hist;
  logic [PH_W-1:0]          phase;
  logic signed [ACC_W-1:0]  acc;
  logic signed [OUT_W-1:0]  sat;

  shaper_history #(.DEPTH(NSYM)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync),
    .run      (run),
    .sym_stb  (sym_stb),
    .sym_code (sym_code),
    .hist     (hist)
  );

  shaper_phase #(.NPH(UPS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync),
    .run     (run),
    .sym_stb (sym_stb),
    .smp_stb (smp_stb),
    .phase   (phase)
  );

  shaper_mac #(.OUT_W(OUT_W), .ACC_W(ACC_W)) u_mac (
    .hist  (hist),
    .phase (phase),
    .acc   (acc),
    .sat   (sat)
  );

  logic signed [OUT_W-1:0] smp_q, smp_nxt;
  logic                    vld_q, vld_nxt;

  always_comb begin
    smp_nxt = smp_q;
    vld_nxt = smp_stb;
    if (smp_stb)
      smp_nxt = run ? sat : '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign smp_out = smp_q;
  assign smp_vld = vld_q;

  // R6: the unclipped polyphase sum fits the output word
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    smp_stb |-> (acc >= LIM_LO && acc <= LIM_HI));

  // R8: valid follows each sample strobe by one cycle
  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    smp_stb |=> smp_vld);

  assert_vld_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    !smp_stb |=> !smp_vld);

  // R8: sample word holds between strobes
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    !smp_stb |=> $stable(smp_out));

  // R7: silenced burst produces zero samples
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (!run && smp_stb) |=> (smp_out == '0));

endmodule

// File: tb/test_pulse_shaper_x8.sv
module test_pulse_shaper_x8;
  timeunit 1ns;
  timeprecision 100ps;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run;
  logic              sym_stb;
  logic [1:0]        sym_code;
  logic              smp_stb;
  logic signed [8:0] smp_out;
  logic              smp_vld;

  always #2.5 clk = ~clk;

  pulse_shaper_x8 i_pulse_shaper_x8 (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sym_stb  (sym_stb),
    .sym_code (sym_code),
    .smp_stb  (smp_stb),
    .smp_out  (smp_out),
    .smp_vld  (smp_vld)
  );

  int    total = 0;
  int    bad   = 0;
  int    exp_q[$];
  string tag_q[$];
  logic [1:0] mh [8];
  int    mph;
  int    last_out = 0;
  bit    mon_on = 0;
  bit    done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Coefficients from the requirement (R5), centre outwards.
  int half_c [32] = '{200, 186, 158, 123, 83, 45, 13, -11, -24, -29, -26, -18, -9, 0, 5, 8,
                      7, 4, 1, -2, -3, -3, -2, 0, 1, 3, 3, 2, 1, 0, -1, -2};

  function automatic int bc(int n);
    return (n >= 32) ? half_c[n - 32] : half_c[31 - n];
  endfunction

  function automatic int sv(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int model_sample();
    int s = 0;
    if (!run) return 0;
    for (int i = 0; i < 8; i++) s += sv(mh[i]) * bc(mph + 8 * i);
    if (s > 255) s = 255;
    if (s < -256) s = -256;
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(bit do_sym, logic [1:0] c, bit do_smp, string tag);
    @(negedge clk);
    sym_stb  = do_sym;
    sym_code = c;
    smp_stb  = do_smp;
    if (do_smp) begin
      exp_q.push_back(model_sample());
      tag_q.push_back(tag);
    end
    if (run) begin
      if (do_sym) begin
        for (int i = 7; i > 0; i--) mh[i] = mh[i-1];
        mh[0] = c;
        mph = 0;
      end else if (do_smp) begin
        mph = (mph + 1) % 8;
      end
    end
    @(negedge clk);
    sym_stb = 1'b0;
    smp_stb = 1'b0;
  endtask

  task automatic set_run(bit v);
    @(negedge clk);
    run = v;
    if (!v) begin
      for (int i = 0; i < 8; i++) mh[i] = 2'b00;
      mph = 0;
    end
  endtask

  task automatic symbol_then_samples(logic [1:0] c, int n, string tag);
    drive(1'b1, c, 1'b0, tag);
    for (int k = 0; k < n; k++) drive(1'b0, 2'b00, 1'b1, tag);
  endtask

  // Scoreboard monitor: compares each produced sample against the queue.
  always @(negedge clk) begin
    int    e;
    string t;
    if (mon_on) begin
      if (smp_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected valid", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(smp_out) == e, t, int'(smp_out), e);
        end
        last_out = int'(smp_out);
      end else begin
        check(int'(smp_out) == last_out, "R8 hold", int'(smp_out), last_out);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; sym_stb = 1'b0; smp_stb = 1'b0; sym_code = 2'b00;
    for (int i = 0; i < 8; i++) mh[i] = 2'b00;
    mph = 0;
    repeat (3) @(negedge clk);
    check(smp_out == 0, "R1 out in reset", int'(smp_out), 0);
    check(smp_vld == 0, "R1 vld in reset", int'(smp_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(smp_out == 0, "R1 out after reset", int'(smp_out), 0);
    check(smp_vld == 0, "R1 vld after reset", int'(smp_vld), 0);
    mon_on = 1;
    set_run(1'b1);
    drive(1'b0, 2'b00, 1'b1, "R1 first sample");

    // R5: +1 impulse reads out all 64 taps in order
    for (int m = 0; m < 8; m++) symbol_then_samples((m == 0) ? 2'b01 : 2'b00, 8, "R5 impulse");
    // R2: -1 impulse, then code 10 counts as zero
    for (int m = 0; m < 8; m++) symbol_then_samples((m == 0) ? 2'b11 : 2'b00, 8, "R2 neg impulse");
    for (int m = 0; m < 8; m++) symbol_then_samples((m == 0) ? 2'b10 : 2'b00, 8, "R2 code10");

    // R6: sign pattern aligned to phase 0 gives the 253 peak, then its negation
    begin
      logic [1:0] pat [8] = '{2'b01, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01, 2'b01, 2'b11};
      for (int i = 0; i < 7; i++) drive(1'b1, pat[i], 1'b0, "R6");
      drive(1'b1, pat[7], 1'b0, "R6");
      check(model_sample() == 253, "R6 model peak", model_sample(), 253);
      drive(1'b0, 2'b00, 1'b1, "R6 peak +253");
      for (int i = 0; i < 8; i++) drive(1'b1, (pat[i] == 2'b01) ? 2'b11 : 2'b01, 1'b0, "R6");
      drive(1'b0, 2'b00, 1'b1, "R6 peak -253");
    end

    // R4: pseudo-random burst
    for (int s = 0; s < 40; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      symbol_then_samples(lfsr[1:0], 8, "R4 random");
    end

    // R3: short period, long period with wrap, coincident strobes
    symbol_then_samples(2'b01, 3, "R3 short");
    symbol_then_samples(2'b11, 11, "R3 wrap");
    drive(1'b1, 2'b01, 1'b1, "R3 coincident");
    for (int k = 0; k < 8; k++) drive(1'b0, 2'b00, 1'b1, "R3 after coincident");

    // R8: valid idles and output holds between samples
    repeat (3) @(negedge clk);
    check(smp_vld == 0, "R8 idle vld", int'(smp_vld), 0);
    check(int'(smp_out) == last_out, "R8 idle hold", int'(smp_out), last_out);

    // R7: burst disable clears history and silences output
    symbol_then_samples(2'b01, 2, "R7 prefill");
    set_run(1'b0);
    drive(1'b1, 2'b01, 1'b1, "R7 sym ignored");
    drive(1'b0, 2'b00, 1'b1, "R7 quiet");
    set_run(1'b1);
    drive(1'b0, 2'b00, 1'b1, "R7 cleared");
    for (int m = 0; m < 2; m++) symbol_then_samples((m == 0) ? 2'b01 : 2'b00, 8, "R7 fresh burst");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 all samples produced", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule